// File: doc/BRIEF.md
# UART Interrupt Enable and Identification Logic

This block is the interrupt controller of a UART with 16-entry receive and transmit FIFOs. A host bus writes and reads back an 8-bit interrupt enable register. The block also takes live status from the rest of the UART: the receive holding register and FIFO fill level, the programmed receive trigger, the transmit holding register and FIFO state, the four receive error flags and the four modem change flags. From these it forms one active-high interrupt line and an 8-bit interrupt status word. The status word names the most urgent pending source that is enabled.

The receive-data and transmit-empty conditions follow the FIFO mode input. In non-FIFO mode they track the single holding registers. In FIFO mode they track the trigger level and the emptiness of the whole transmit path. An enhanced-mode enable bit adds two bus-visible DMA ready flags to the status word. It also lets two modem-control bits drive a soft reset pin and a power-down pin. A read of the status word that reports transmit-empty acknowledges that interrupt.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After synchronous reset the enable register reads 0x00, the status word reads 0x01 and `irq` is low.
- R2: A write to the enable register stores bits 0, 1, 2, 3 and 5. Bits 4, 6 and 7 always read 0.
- R3: With enable bit 0 set and `fifo_mode` low, the receive-data source is pending exactly while `rhr_full` is high.
- R4: With enable bit 0 set and `fifo_mode` high, the receive-data source is pending while `rx_level >= rx_trig`. It drops once the level falls below the trigger, and `rhr_full` is ignored.
- R5: With enable bit 1 set, the transmit-empty source is pending while `thr_empty` is high in non-FIFO mode. In FIFO mode it is pending only while both `thr_empty` and `tx_fifo_empty` are high.
- R6: With enable bit 2 set, the line-status source is pending while any bit of `lsr_err` (overrun, parity, framing, break) is high.
- R7: With enable bit 3 set, the modem source is pending while any bit of `msr_delta` is high.
- R8: Status bits 3:1 hold the code of the highest-priority pending source. The codes, from highest to lowest priority, are: line status 3'b011, receive data 3'b010, transmit empty 3'b001, modem 3'b000. Status bit 0 is 1 only when nothing is pending.
- R9: A source whose enable bit is 0 never raises `irq` or appears in the status code. `irq` is high exactly when status bit 0 is 0.
- R10: A status read (`isr_rd`) that reports transmit-empty (status 3:0 = 4'b0010) masks that source from the next cycle on. A cycle with `thr_write` high removes the mask. A status read that reports any other source leaves transmit-empty unmasked.
- R11: When enable bit 5 is set, status bit 4 is the transmit-ready flag and status bit 5 is the receive-ready flag. Otherwise both bits read 0. In DMA mode 0 (`dma_mode` low or `fifo_mode` low), receive-ready means `rhr_full` (non-FIFO) or a non-zero `rx_level` (FIFO). In the same mode, transmit-ready means the transmit-empty condition of R5. In DMA mode 1 (`dma_mode` and `fifo_mode` high), receive-ready means `rx_level >= rx_trig` and transmit-ready means `tx_fifo_full` is low.
- R12: `soft_rst_o` follows `mcr_rst_bit` and `pwrdn_o` follows `mcr_pwrdn_bit` only while enable bit 5 is set. Otherwise both outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| ier_rdata | output | 8 | Enable register read data |
| isr_rd | input | 1 | Status word read strobe |
| isr_rdata | output | 8 | Interrupt status word |
| fifo_mode | input | 1 | FIFOs enabled |
| dma_mode | input | 1 | DMA mode select (1 = block mode) |
| rhr_full | input | 1 | Receive holding register holds a character |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_trig | input | LVL_W | Programmed receive trigger level |
| thr_empty | input | 1 | Transmit holding register empty |
| tx_fifo_empty | input | 1 | Transmit FIFO empty |
| tx_fifo_full | input | 1 | Transmit FIFO full |
| thr_write | input | 1 | Host wrote transmit data this cycle |
| lsr_err | input | 4 | Overrun, parity, framing, break flags |
| msr_delta | input | 4 | Modem status change flags |
| mcr_rst_bit | input | 1 | Modem control soft-reset bit |
| mcr_pwrdn_bit | input | 1 | Modem control power-down bit |
| irq | output | 1 | Interrupt request, active high |
| soft_rst_o | output | 1 | Soft reset pin |
| pwrdn_o | output | 1 | Power-down pin |

## Verification
The bench builds the block with its default depth of 16, so `rx_level` and `rx_trig` are 5 bits wide. The bench drives the fill level one below the trigger, at the trigger and at the full depth of 16. These values reach both edges of the FIFO-mode receive comparison and both DMA ready modes. Each error and modem flag is driven alone, which shows that every bit reaches the line and modem sources. The acknowledge path is covered both when transmit-empty is the reported source and when a higher source hides it.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int REG_W   = 8;
    localparam int NUM_SRC = 4;
    localparam int ERR_W   = 4;
    localparam int DLT_W   = 4;

    // enable register bit positions
    localparam int EN_RXD   = 0;
    localparam int EN_TXE   = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;
    localparam int EN_ENH   = 5;

    localparam logic [REG_W-1:0] EN_WRITABLE = 8'h2F;

    // priority codes placed in status bits 3:1
    typedef enum logic [2:0] {
        CODE_MODEM = 3'b000,
        CODE_TXE   = 3'b001,
        CODE_RXD   = 3'b010,
        CODE_LINE  = 3'b011
    } irq_code_e;

    // sources, most urgent in the top bit
    typedef struct packed {
        logic line;
        logic rxd;
        logic txe;
        logic modem;
    } irq_src_t;

    typedef struct packed {
        logic rx_ready;
        logic tx_ready;
    } dma_flags_t;

    typedef struct packed {
        logic [1:0] rsvd;
        dma_flags_t dma;
        irq_code_e  code;
        logic       idle;
    } isr_word_t;

    // code of source index, index NUM_SRC-1 is most urgent
    function automatic irq_code_e code_of(input int idx);
        case (idx)
            3:       return CODE_LINE;
            2:       return CODE_RXD;
            1:       return CODE_TXE;
            default: return CODE_MODEM;
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_ier_reg.sv
module uart_irq_ier_reg
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] ier_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ier_q <= '0;
        end else if (wr) begin
            ier_q <= wdata & EN_WRITABLE;
        end
    end

endmodule

// File: rtl/uart_irq_src.sv
module uart_irq_src
    import uart_irq_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic             fifo_mode,
    input  logic             dma_mode,
    input  logic             rhr_full,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] rx_trig,
    input  logic             thr_empty,
    input  logic             tx_fifo_empty,
    input  logic             tx_fifo_full,
    input  logic [ERR_W-1:0] lsr_err,
    input  logic [DLT_W-1:0] msr_delta,
    input  logic [REG_W-1:0] ier,
    input  logic             tx_masked,
    output irq_src_t         pend,
    output dma_flags_t       dma
);

    logic rx_at_trig;
    logic rx_cond;
    logic tx_cond;
    logic block_mode;

    always_comb begin
        rx_at_trig = (rx_level >= rx_trig);
        rx_cond    = fifo_mode ? rx_at_trig : rhr_full;
        tx_cond    = fifo_mode ? (thr_empty & tx_fifo_empty) : thr_empty;
        block_mode = fifo_mode & dma_mode;

        pend.line  = ier[EN_LINE]  & (|lsr_err);
        pend.rxd   = ier[EN_RXD]   & rx_cond;
        pend.txe   = ier[EN_TXE]   & tx_cond & ~tx_masked;
        pend.modem = ier[EN_MODEM] & (|msr_delta);

        if (block_mode) begin
            dma.rx_ready = rx_at_trig;
            dma.tx_ready = ~tx_fifo_full;
        end else begin
            dma.rx_ready = fifo_mode ? (rx_level != '0) : rhr_full;
            dma.tx_ready = tx_cond;
        end
    end

endmodule

// File: rtl/uart_irq_txack.sv
module uart_irq_txack (
    input  logic clk,
    input  logic rst,
    input  logic isr_rd,
    input  logic tx_reported,
    input  logic thr_write,
    output logic tx_masked
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_masked <= 1'b0;
        end else if (thr_write) begin
            tx_masked <= 1'b0;
        end else if (isr_rd && tx_reported) begin
            tx_masked <= 1'b1;
        end
    end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  irq_src_t  pend,
    output irq_code_e code,
    output logic      idle
);

    logic [NUM_SRC-1:0] req;
    logic [NUM_SRC:0]   above;
    logic [NUM_SRC-1:0] win;
    logic [2:0]         code_bits [NUM_SRC];

    assign req = pend;
    assign above[NUM_SRC] = 1'b0;

    for (genvar i = NUM_SRC - 1; i >= 0; i--) begin : g_chain
        assign win[i]       = req[i] & ~above[i+1];
        assign above[i]     = above[i+1] | req[i];
        assign code_bits[i] = win[i] ? code_of(i) : 3'b000;
    end

    always_comb begin
        logic [2:0] acc;
        acc = 3'b000;
        for (int i = 0; i < NUM_SRC; i++) begin
            acc = acc | code_bits[i];
        end
        code = irq_code_e'(acc);
        idle = ~above[0];
    end

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int  FIFO_DEPTH = 16,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ier_wr,
    input  logic [7:0]       ier_wdata,
    output logic [7:0]       ier_rdata,
    input  logic             isr_rd,
    output logic [7:0]       isr_rdata,
    input  logic             fifo_mode,
    input  logic             dma_mode,
    input  logic             rhr_full,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] rx_trig,
    input  logic             thr_empty,
    input  logic             tx_fifo_empty,
    input  logic             tx_fifo_full,
    input  logic             thr_write,
    input  logic [3:0]       lsr_err,
    input  logic [3:0]       msr_delta,
    input  logic             mcr_rst_bit,
    input  logic             mcr_pwrdn_bit,
    output logic             irq,
    output logic             soft_rst_o,
    output logic             pwrdn_o
);

    logic [REG_W-1:0] ier_q;
    logic             tx_masked;
    irq_src_t         pend;
    dma_flags_t       dma;
    irq_code_e        code;
    logic             idle;
    isr_word_t        isr;
    logic             enh;

    uart_irq_ier_reg u_ier (
        .clk   (clk),
        .rst   (rst),
        .wr    (ier_wr),
        .wdata (ier_wdata),
        .ier_q (ier_q)
    );

    uart_irq_src #(.LVL_W(LVL_W)) u_src (
        .fifo_mode     (fifo_mode),
        .dma_mode      (dma_mode),
        .rhr_full      (rhr_full),
        .rx_level      (rx_level),
        .rx_trig       (rx_trig),
        .thr_empty     (thr_empty),
        .tx_fifo_empty (tx_fifo_empty),
        .tx_fifo_full  (tx_fifo_full),
        .lsr_err       (lsr_err),
        .msr_delta     (msr_delta),
        .ier           (ier_q),
        .tx_masked     (tx_masked),
        .pend          (pend),
        .dma           (dma)
    );

    uart_irq_prio u_prio (
        .pend (pend),
        .code (code),
        .idle (idle)
    );

    uart_irq_txack u_txack (
        .clk         (clk),
        .rst         (rst),
        .isr_rd      (isr_rd),
        .tx_reported (!idle && code == CODE_TXE),
        .thr_write   (thr_write),
        .tx_masked   (tx_masked)
    );

    always_comb begin
        enh       = ier_q[EN_ENH];
        isr.rsvd  = 2'b00;
        isr.dma   = enh ? dma : '0;
        isr.code  = idle ? CODE_MODEM : code;
        isr.idle  = idle;
    end

    assign isr_rdata  = isr;
    assign ier_rdata  = ier_q;
    assign irq        = ~idle;
    assign soft_rst_o = enh & mcr_rst_bit;
    assign pwrdn_o    = enh & mcr_pwrdn_bit;

endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       ier_wr,
    input logic [7:0] ier_wdata,
    input logic [7:0] ier_rdata,
    input logic       isr_rd,
    input logic [7:0] isr_rdata,
    input logic       thr_write,
    input logic [3:0] lsr_err,
    input logic       irq,
    input logic       soft_rst_o,
    input logic       pwrdn_o
);

    assert_ier_write_R2: assert property (@(posedge clk) disable iff (rst)
        ier_wr |=> ier_rdata == ($past(ier_wdata) & 8'h2F));

    assert_line_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (ier_rdata[2] && (|lsr_err)) |-> isr_rdata[3:0] == 4'b0110);

    assert_irq_vs_status_R9: assert property (@(posedge clk) disable iff (rst)
        irq != isr_rdata[0]);

    assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (ier_rdata[3:0] == 4'b0000) |-> !irq);

    assert_tx_ack_R10: assert property (@(posedge clk) disable iff (rst)
        (isr_rd && isr_rdata[3:0] == 4'b0010 && !thr_write) |=> isr_rdata[3:0] != 4'b0010);

    assert_enh_off_R11: assert property (@(posedge clk) disable iff (rst)
        !ier_rdata[5] |-> isr_rdata[5:4] == 2'b00);

    assert_pins_gated_R12: assert property (@(posedge clk) disable iff (rst)
        (pwrdn_o || soft_rst_o) |-> ier_rdata[5]);

endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ier_wr     (ier_wr),
    .ier_wdata  (ier_wdata),
    .ier_rdata  (ier_rdata),
    .isr_rd     (isr_rd),
    .isr_rdata  (isr_rdata),
    .thr_write  (thr_write),
    .lsr_err    (lsr_err),
    .irq        (irq),
    .soft_rst_o (soft_rst_o),
    .pwrdn_o    (pwrdn_o)
);

// File: tb/tb_uart_irq_ctrl.sv
module tb_uart_irq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int LW         = $clog2(DEPTH + 1);
    localparam int WDOG_LIMIT = 20000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ier_wr = 1'b0;
    logic [7:0]    ier_wdata = '0;
    logic [7:0]    ier_rdata;
    logic          isr_rd = 1'b0;
    logic [7:0]    isr_rdata;
    logic          fifo_mode = 1'b0;
    logic          dma_mode = 1'b0;
    logic          rhr_full = 1'b0;
    logic [LW-1:0] rx_level = '0;
    logic [LW-1:0] rx_trig = LW'(1);
    logic          thr_empty = 1'b0;
    logic          tx_fifo_empty = 1'b0;
    logic          tx_fifo_full = 1'b0;
    logic          thr_write = 1'b0;
    logic [3:0]    lsr_err = '0;
    logic [3:0]    msr_delta = '0;
    logic          mcr_rst_bit = 1'b0;
    logic          mcr_pwrdn_bit = 1'b0;
    logic          irq;
    logic          soft_rst_o;
    logic          pwrdn_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_irq_ctrl #(.FIFO_DEPTH(DEPTH)) dut (
        .clk           (clk),
        .rst           (rst),
        .ier_wr        (ier_wr),
        .ier_wdata     (ier_wdata),
        .ier_rdata     (ier_rdata),
        .isr_rd        (isr_rd),
        .isr_rdata     (isr_rdata),
        .fifo_mode     (fifo_mode),
        .dma_mode      (dma_mode),
        .rhr_full      (rhr_full),
        .rx_level      (rx_level),
        .rx_trig       (rx_trig),
        .thr_empty     (thr_empty),
        .tx_fifo_empty (tx_fifo_empty),
        .tx_fifo_full  (tx_fifo_full),
        .thr_write     (thr_write),
        .lsr_err       (lsr_err),
        .msr_delta     (msr_delta),
        .mcr_rst_bit   (mcr_rst_bit),
        .mcr_pwrdn_bit (mcr_pwrdn_bit),
        .irq           (irq),
        .soft_rst_o    (soft_rst_o),
        .pwrdn_o       (pwrdn_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic write_ier(input logic [7:0] v);
        @(negedge clk);
        ier_wr    = 1'b1;
        ier_wdata = v;
        @(negedge clk);
        ier_wr    = 1'b0;
        #1;
    endtask

    task automatic clear_inputs();
        @(negedge clk);
        fifo_mode = 0; dma_mode = 0; rhr_full = 0; rx_level = '0; rx_trig = LW'(1);
        thr_empty = 0; tx_fifo_empty = 0; tx_fifo_full = 0; thr_write = 0;
        lsr_err = '0; msr_delta = '0; mcr_rst_bit = 0; mcr_pwrdn_bit = 0;
    endtask

    task automatic t_reset();
        #1;
        check("R1 ier", ier_rdata, 8'h00);
        check("R1 isr", isr_rdata, 8'h01);
        check("R1 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_ier_rw();
        write_ier(8'hFF);
        check("R2 reserved bits", ier_rdata, 8'h2F);
        write_ier(8'h00);
        check("R2 cleared", ier_rdata, 8'h00);
    endtask

    task automatic t_rx_nonfifo();
        write_ier(8'h01);
        rhr_full = 1; settle();
        check("R3 rhr full", isr_rdata, 8'h04);
        check("R3 irq", {7'd0, irq}, 8'h01);
        rhr_full = 0; settle();
        check("R3 rhr empty", isr_rdata, 8'h01);
    endtask

    task automatic t_rx_fifo();
        write_ier(8'h01);
        fifo_mode = 1; rx_trig = LW'(8); rx_level = LW'(7); rhr_full = 1; settle();
        check("R4 below trigger, rhr ignored", isr_rdata, 8'h01);
        rx_level = LW'(8); settle();
        check("R4 at trigger", isr_rdata, 8'h04);
        rx_level = LW'(DEPTH); settle();
        check("R4 full depth", isr_rdata, 8'h04);
        rx_level = LW'(7); settle();
        check("R4 falls below", isr_rdata, 8'h01);
        clear_inputs();
    endtask

    task automatic t_tx();
        write_ier(8'h02);
        thr_empty = 1; settle();
        check("R5 nonfifo thr empty", isr_rdata, 8'h02);
        fifo_mode = 1; settle();
        check("R5 fifo not empty", isr_rdata, 8'h01);
        tx_fifo_empty = 1; settle();
        check("R5 fifo and thr empty", isr_rdata, 8'h02);
        thr_empty = 0; settle();
        check("R5 thr busy", isr_rdata, 8'h01);
        clear_inputs();
    endtask

    task automatic t_lsr();
        write_ier(8'h04);
        for (int i = 0; i < 4; i++) begin
            lsr_err = 4'b0001 << i; settle();
            check("R6 line bit", isr_rdata, 8'h06);
        end
        lsr_err = '0; settle();
        check("R6 no error", isr_rdata, 8'h01);
    endtask

    task automatic t_msr();
        write_ier(8'h08);
        for (int i = 0; i < 4; i++) begin
            msr_delta = 4'b0001 << i; settle();
            check("R7 modem bit", isr_rdata, 8'h00);
            check("R7 irq", {7'd0, irq}, 8'h01);
        end
        msr_delta = '0; settle();
        check("R7 no change", isr_rdata, 8'h01);
    endtask

    task automatic t_disabled();
        write_ier(8'h20);
        rhr_full = 1; thr_empty = 1; lsr_err = 4'hF; msr_delta = 4'hF; settle();
        check("R9 all disabled isr", isr_rdata & 8'h0F, 8'h01);
        check("R9 all disabled irq", {7'd0, irq}, 8'h00);
        write_ier(8'h00);
        clear_inputs();
    endtask

    task automatic t_priority();
        write_ier(8'h0F);
        rhr_full = 1; thr_empty = 1; lsr_err = 4'h2; msr_delta = 4'h1; settle();
        check("R8 line first", isr_rdata, 8'h06);
        lsr_err = '0; settle();
        check("R8 rx second", isr_rdata, 8'h04);
        rhr_full = 0; settle();
        check("R8 tx third", isr_rdata, 8'h02);
        thr_empty = 0; settle();
        check("R8 modem last", isr_rdata, 8'h00);
        msr_delta = '0; settle();
        check("R8 idle", isr_rdata, 8'h01);
    endtask

    task automatic t_tx_ack();
        write_ier(8'h02);
        thr_empty = 1; settle();
        check("R10 before read", isr_rdata, 8'h02);
        @(negedge clk); isr_rd = 1;
        @(negedge clk); isr_rd = 0; #1;
        check("R10 masked after read", isr_rdata, 8'h01);
        @(negedge clk); thr_write = 1; thr_empty = 0;
        @(negedge clk); thr_write = 0; #1;
        check("R10 busy after write", isr_rdata, 8'h01);
        thr_empty = 1; settle();
        check("R10 rearmed", isr_rdata, 8'h02);
        write_ier(8'h06);
        lsr_err = 4'h1; settle();
        check("R10 line reported", isr_rdata, 8'h06);
        @(negedge clk); isr_rd = 1;
        @(negedge clk); isr_rd = 0;
        lsr_err = '0; #1;
        check("R10 tx not acked by other read", isr_rdata, 8'h02);
        write_ier(8'h00);
        clear_inputs();
    endtask

    task automatic t_enh_flags();
        write_ier(8'h20);
        rhr_full = 1; thr_empty = 1; settle();
        check("R11 mode0 nonfifo both", isr_rdata, 8'h31);
        rhr_full = 0; thr_empty = 0; settle();
        check("R11 mode0 nonfifo none", isr_rdata, 8'h01);
        fifo_mode = 1; dma_mode = 1; rx_trig = LW'(4); rx_level = LW'(3); settle();
        check("R11 mode1 below trig", isr_rdata, 8'h11);
        rx_level = LW'(4); settle();
        check("R11 mode1 at trig", isr_rdata, 8'h31);
        tx_fifo_full = 1; settle();
        check("R11 mode1 tx full", isr_rdata, 8'h21);
        dma_mode = 0; rx_level = LW'(1); tx_fifo_full = 0; settle();
        check("R11 mode0 fifo nonempty", isr_rdata, 8'h21);
        write_ier(8'h00);
        check("R11 enhanced off", isr_rdata, 8'h01);
        clear_inputs();
    endtask

    task automatic t_enh_pins();
        mcr_rst_bit = 1; mcr_pwrdn_bit = 1; settle();
        check("R12 pins gated off", {6'd0, soft_rst_o, pwrdn_o}, 8'h00);
        write_ier(8'h20);
        check("R12 pins enabled", {6'd0, soft_rst_o, pwrdn_o}, 8'h03);
        mcr_pwrdn_bit = 0; settle();
        check("R12 pwrdn follows", {6'd0, soft_rst_o, pwrdn_o}, 8'h02);
        write_ier(8'h00);
        clear_inputs();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (WDOG_LIMIT) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ier_rw();
        t_rx_nonfifo();
        t_rx_fifo();
        t_tx();
        t_lsr();
        t_msr();
        t_disabled();
        t_priority();
        t_tx_ack();
        t_enh_flags();
        t_enh_pins();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule